// File: doc/BRIEF.md
# Edge-Triggered Interrupt Request Controller

This block watches six external interrupt pins. Each pin passes through a two-stage synchroniser into a small edge-tracking state machine. The machine follows the last synchronised level of the pin. Each channel has one byte-wide control register. The register selects which transition counts as an event (falling or rising). It also holds a 3-bit priority and a sticky pending flag that hardware sets. A separate register holds one bit per channel; when that bit is set, the channel counts both transitions.

Software reaches the registers over a plain bus: a channel address, a write strobe with write data, and registered read data. Software can clear the pending flag but can never set it. The block presents every channel's pending flag and priority on its outputs. It also forwards the single most urgent qualified request, so that a later stage can do vectoring and acknowledgement.

The edge tracker of each channel has two states. LVL_LOW means the last synchronised sample was 0, and LVL_HIGH means it was 1. The transition LVL_LOW→LVL_HIGH (rise) signals an event when the channel is in rising or both-edge mode. The transition LVL_HIGH→LVL_LOW (fall) signals an event when the channel is in falling or both-edge mode. With no change of level the tracker stays in its current state. After reset it is in LVL_LOW.

Top module: `irq_edge_ctrl`

## Requirements
- R1: After reset every channel control register, the both-edge register and all outputs read 0, and `req_valid` is 0.
- R2: Bits 2:0 of a channel control register (addresses 0 to 5) hold its priority level, where 0 means disabled. They read back as written and appear on `chan_lvl[3*i+2:3*i]`.
- R3: When bit 4 (polarity) is 0 and both-edge mode is off, a falling edge on `irq_pin[i]` sets pending bit 3. The flag becomes visible on the third rising clock edge after the pin changes.
- R4: When polarity is 1 and both-edge mode is off, a rising edge sets pending. In either polarity mode the opposite edge leaves the flag unchanged.
- R5: Bit i of the both-edge register at address 6 makes channel i set its pending flag on every edge of either direction, whatever the polarity bit holds.
- R6: A register write with bit 3 = 0 clears the pending flag. A write with bit 3 = 1 leaves the flag as it was and never sets it.
- R7: When an event and a clearing write land in the same cycle, the pending flag ends up set.
- R8: Bit 5 of a control register is stored and reads back as written. Bits 7:6 and bits 7:6 of the both-edge register always read 0. Address 7 reads 0, and writes to it have no effect.
- R9: `req_valid` is 1 exactly when some channel is pending with a nonzero level. `req_chan` and `req_lvl` then name the highest level, and a tie goes to the lowest channel number. With no request, both read 0.
- R10: `rd_data` shows the register at `bus_addr` as it stood before the clock edge, one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin | input | 6 | External interrupt pins, asynchronous |
| bus_addr | input | 3 | Register select: 0-5 channel, 6 both-edge, 7 none |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| chan_pend | output | 6 | Pending flag per channel |
| chan_lvl | output | 18 | Priority level per channel, 3 bits each |
| req_valid | output | 1 | A qualified request exists |
| req_chan | output | 3 | Channel of the winning request |
| req_lvl | output | 3 | Level of the winning request |

## Verification
The assertions assume that reset is applied before the first check. They also assume that the pins are low during reset, so the trackers start from a known level. The assertions do not need the pins to follow any rule about pulse width. An event can come only from a tracker transition, so the bench can toggle pins at random every cycle and also drive random bus writes, including writes to the spare address. The polarity rule for both-edge channels is not enforced in hardware. For that reason the random stimulus writes the polarity bit freely, and the expected model ignores polarity whenever both-edge mode is on.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int LVL_W = 3;
    localparam int DW    = 8;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } pin_state_e;

    typedef struct packed {
        logic [1:0]       spare;
        logic             rsv;
        logic             pol;
        logic             pend;
        logic [LVL_W-1:0] lvl;
    } ctl_reg_t;
endpackage

// File: rtl/irq_edge_fsm.sv
module irq_edge_fsm
    import irq_pkg::*;
#(
    parameter int NCH = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] pin,
    input  logic [NCH-1:0] pol,
    input  logic [NCH-1:0] both,
    output logic [NCH-1:0] edge_hit
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic       s1_q, s2_q;
        pin_state_e state_q, state_n;
        logic       hit;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q <= 1'b0;
                s2_q <= 1'b0;
            end else begin
                s1_q <= pin[i];
                s2_q <= s1_q;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) state_q <= LVL_LOW;
            else        state_q <= state_n;
        end

        always_comb begin
            state_n = state_q;
            hit     = 1'b0;
            unique case (state_q)
                LVL_LOW: if (s2_q) begin
                    state_n = LVL_HIGH;
                    hit     = both[i] | pol[i];
                end
                LVL_HIGH: if (!s2_q) begin
                    state_n = LVL_LOW;
                    hit     = both[i] | ~pol[i];
                end
                default: state_n = LVL_LOW;
            endcase
        end

        assign edge_hit[i] = hit;
    end
endmodule

// File: rtl/irq_chan_regs.sv
module irq_chan_regs
    import irq_pkg::*;
#(
    parameter int NCH    = 6,
    parameter int ADDR_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DW-1:0]         wdata,
    input  logic [NCH-1:0]        edge_hit,
    output ctl_reg_t [NCH-1:0]    ctl,
    output logic [NCH-1:0]        both,
    output logic [DW-1:0]         rd_data
);
    localparam logic [ADDR_W-1:0] BOTH_ADDR = ADDR_W'(NCH);

    ctl_reg_t [NCH-1:0] ctl_q;
    logic [NCH-1:0]     both_q;
    logic [DW-1:0]      rd_next;

    for (genvar i = 0; i < NCH; i++) begin : g_reg
        logic sel;
        assign sel = wr && (addr == ADDR_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ctl_q[i] <= '0;
            end else begin
                if (sel) begin
                    ctl_q[i].lvl <= wdata[LVL_W-1:0];
                    ctl_q[i].pol <= wdata[4];
                    ctl_q[i].rsv <= wdata[5];
                end
                // event beats a clearing write; writing one never sets
                ctl_q[i].pend <= edge_hit[i] |
                                 (ctl_q[i].pend & (~sel | wdata[3]));
                ctl_q[i].spare <= 2'b00;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        both_q <= '0;
        else if (wr && addr == BOTH_ADDR)  both_q <= wdata[NCH-1:0];
    end

    always_comb begin
        rd_next = '0;
        for (int i = 0; i < NCH; i++) begin
            if (addr == ADDR_W'(i)) begin
                rd_next      = ctl_q[i];
                rd_next[7:6] = 2'b00;
            end
        end
        if (addr == BOTH_ADDR) rd_next[NCH-1:0] = both_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= rd_next;
    end

    assign ctl  = ctl_q;
    assign both = both_q;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_pkg::*;
#(
    parameter int NCH    = 6,
    parameter int ADDR_W = 3
) (
    input  logic [NCH-1:0]            pend,
    input  logic [NCH-1:0][LVL_W-1:0] lvl,
    output logic                      valid,
    output logic [ADDR_W-1:0]         chan,
    output logic [LVL_W-1:0]          win_lvl
);
    always_comb begin
        chan    = '0;
        win_lvl = '0;
        for (int i = 0; i < NCH; i++) begin
            if (pend[i] && (lvl[i] > win_lvl)) begin
                win_lvl = lvl[i];
                chan    = ADDR_W'(i);
            end
        end
        valid = (win_lvl != '0);
    end
endmodule

// File: rtl/irq_edge_ctrl.sv
module irq_edge_ctrl
    import irq_pkg::*;
#(
    parameter int NCH = 6,
    localparam int ADDR_W = $clog2(NCH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NCH-1:0]         irq_pin,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic                   bus_wr,
    input  logic [DW-1:0]          bus_wdata,
    output logic [DW-1:0]          rd_data,
    output logic [NCH-1:0]         chan_pend,
    output logic [NCH*LVL_W-1:0]   chan_lvl,
    output logic                   req_valid,
    output logic [ADDR_W-1:0]      req_chan,
    output logic [LVL_W-1:0]       req_lvl
);
    ctl_reg_t [NCH-1:0]            ctl;
    logic [NCH-1:0]                both;
    logic [NCH-1:0]                pol;
    logic [NCH-1:0]                edge_hit;
    logic [NCH-1:0][LVL_W-1:0]     lvl;

    for (genvar i = 0; i < NCH; i++) begin : g_map
        assign pol[i]                   = ctl[i].pol;
        assign chan_pend[i]             = ctl[i].pend;
        assign lvl[i]                   = ctl[i].lvl;
        assign chan_lvl[i*LVL_W +: LVL_W] = ctl[i].lvl;
    end

    irq_edge_fsm #(.NCH(NCH)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (irq_pin),
        .pol      (pol),
        .both     (both),
        .edge_hit (edge_hit)
    );

    irq_chan_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .edge_hit (edge_hit),
        .ctl      (ctl),
        .both     (both),
        .rd_data  (rd_data)
    );

    irq_prio_pick #(.NCH(NCH), .ADDR_W(ADDR_W)) u_pick (
        .pend    (chan_pend),
        .lvl     (lvl),
        .valid   (req_valid),
        .chan    (req_chan),
        .win_lvl (req_lvl)
    );
endmodule

// File: rtl/irq_edge_ctrl_chk.sv
module irq_edge_ctrl_chk #(
    parameter int NCH    = 6,
    parameter int ADDR_W = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_wr,
    input logic [7:0]           bus_wdata,
    input logic [7:0]           rd_data,
    input logic [NCH-1:0]       chan_pend,
    input logic [NCH*3-1:0]     chan_lvl,
    input logic                 req_valid,
    input logic [ADDR_W-1:0]    req_chan,
    input logic [2:0]           req_lvl,
    input logic [NCH-1:0]       edge_hit
);
    p_spare_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7:6] == 2'b00);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        // R3 / R4 / R5: the flag rises only after a tracker event
        p_set_by_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(chan_pend[i]) |-> $past(edge_hit[i]));

        p_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
            edge_hit[i] |=> chan_pend[i]);

        p_write_one_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == ADDR_W'(i) && bus_wdata[3] && chan_pend[i])
            |=> chan_pend[i]);

        p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == ADDR_W'(i) && !bus_wdata[3] && !edge_hit[i])
            |=> !chan_pend[i]);

        p_winner_ok_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && req_chan == ADDR_W'(i)) |->
            (chan_pend[i] && req_lvl != 3'd0 && chan_lvl[i*3 +: 3] == req_lvl));

        p_none_higher_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (chan_pend[i] && chan_lvl[i*3 +: 3] != 3'd0) |->
            (req_valid && req_lvl >= chan_lvl[i*3 +: 3]));
    end
endmodule

bind irq_edge_ctrl irq_edge_ctrl_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .rd_data   (rd_data),
    .chan_pend (chan_pend),
    .chan_lvl  (chan_lvl),
    .req_valid (req_valid),
    .req_chan  (req_chan),
    .req_lvl   (req_lvl),
    .edge_hit  (edge_hit)
);

// File: tb/tb_irq_edge_ctrl.sv
`timescale 1ns/1ps
module tb_irq_edge_ctrl;
    localparam int NCH = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  irq_pin = '0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  rd_data;
    logic [5:0]  chan_pend;
    logic [17:0] chan_lvl;
    logic        req_valid;
    logic [2:0]  req_chan;
    logic [2:0]  req_lvl;

    irq_edge_ctrl dut (.*);

    always #5 clk = ~clk;

    int  n_run = 0, n_fail = 0;
    bit  done = 0;
    string tag = "R1";

    // expected-value model state
    logic [2:0] m_lvl [NCH];
    logic [5:0] m_pol, m_rsv, m_pend, m_both, m_s1, m_s2, m_prev;
    logic [7:0] m_rd;

    task automatic chk(string t, string what, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", t, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_reg(logic [2:0] a);
        if (a < 3'd6) return {2'b00, m_rsv[a], m_pol[a], m_pend[a], m_lvl[a]};
        if (a == 3'd6) return {2'b00, m_both};
        return 8'h00;
    endfunction

    function automatic logic [6:0] exp_req();
        logic [2:0] bl = 0, bc = 0;
        for (int i = 0; i < NCH; i++)
            if (m_pend[i] && m_lvl[i] > bl) begin bl = m_lvl[i]; bc = 3'(i); end
        return {bl != 0, bc, bl};
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NCH; i++) m_lvl[i] = '0;
        {m_pol, m_rsv, m_pend, m_both, m_s1, m_s2, m_prev} = '0;
        m_rd = '0;
    endtask

    task automatic compare();
        logic [17:0] lv;
        logic [6:0]  rq;
        for (int i = 0; i < NCH; i++) lv[i*3 +: 3] = m_lvl[i];
        rq = exp_req();
        chk(tag, "chan_pend", 32'(chan_pend), 32'(m_pend));
        chk(tag, "chan_lvl", 32'(chan_lvl), 32'(lv));
        chk(tag, "req", 32'({req_valid, req_chan, req_lvl}), 32'(rq));
        chk(tag, "rd_data", 32'(rd_data), 32'(m_rd));
    endtask

    // one clock: update model at the edge, compare at the falling edge
    task automatic step();
        logic [5:0] hit, sel;
        @(posedge clk);
        m_rd = exp_reg(bus_addr);
        hit = (m_s2 ^ m_prev) & (m_both | (m_s2 & m_pol) | (~m_s2 & ~m_pol));
        sel = '0;
        if (bus_wr && bus_addr < 3'd6) sel[bus_addr] = 1'b1;
        for (int i = 0; i < NCH; i++) begin
            m_pend[i] = hit[i] | (m_pend[i] & (~sel[i] | bus_wdata[3]));
            if (sel[i]) begin
                m_lvl[i] = bus_wdata[2:0];
                m_pol[i] = bus_wdata[4];
                m_rsv[i] = bus_wdata[5];
            end
        end
        if (bus_wr && bus_addr == 3'd6) m_both = bus_wdata[5:0];
        m_prev = m_s2; m_s2 = m_s1; m_s1 = irq_pin;
        @(negedge clk);
        compare();
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a);
        bus_addr = a;
        step();
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) step();
    endtask

    initial begin
        #(10 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of every address
        tag = "R1";
        compare();
        for (int a = 0; a < 8; a++) rd(3'(a));
        // R2 / R8 / R10: field readback, spare bits, address 7
        tag = "R2"; wr(3'd2, 8'h05); rd(3'd2);
        chk("R2", "lvl out", 32'(chan_lvl[8:6]), 32'd5);
        tag = "R8"; wr(3'd1, 8'hE3); rd(3'd1);
        chk("R8", "rsv kept, spare zero", 32'(rd_data), 32'h23);
        wr(3'd7, 8'hFF); rd(3'd7); rd(3'd6);
        chk("R8", "addr7 write no effect", 32'(rd_data), 32'h00);
        tag = "R10"; bus_addr = 3'd1; wr(3'd1, 8'h04);
        chk("R10", "old value before write", 32'(rd_data), 32'h23);
        // R3: falling edge on channel 0, polarity 0
        tag = "R3"; wr(3'd0, 8'h03);
        irq_pin[0] = 1'b1; idle(4);
        chk("R3", "rise ignored in falling mode", 32'(chan_pend[0]), 32'd0);
        irq_pin[0] = 1'b0; idle(2);
        chk("R3", "not yet after 2 edges", 32'(chan_pend[0]), 32'd0);
        idle(1);
        chk("R3", "set on third edge", 32'(chan_pend[0]), 32'd1);
        // R6: write one keeps, write zero clears, write one never sets
        tag = "R6"; wr(3'd0, 8'h0B);
        chk("R6", "write1 keeps", 32'(chan_pend[0]), 32'd1);
        wr(3'd0, 8'h03);
        chk("R6", "write0 clears", 32'(chan_pend[0]), 32'd0);
        wr(3'd0, 8'h0B);
        chk("R6", "write1 never sets", 32'(chan_pend[0]), 32'd0);
        // R4: rising mode on channel 3
        tag = "R4"; wr(3'd3, 8'h12);
        irq_pin[3] = 1'b1; idle(3);
        chk("R4", "rise sets", 32'(chan_pend[3]), 32'd1);
        wr(3'd3, 8'h12); irq_pin[3] = 1'b0; idle(4);
        chk("R4", "fall ignored in rising mode", 32'(chan_pend[3]), 32'd0);
        // R5: both-edge mode on channel 4
        tag = "R5"; wr(3'd6, 8'h10); wr(3'd4, 8'h01);
        irq_pin[4] = 1'b1; idle(3);
        chk("R5", "rise in both mode", 32'(chan_pend[4]), 32'd1);
        wr(3'd4, 8'h01); irq_pin[4] = 1'b0; idle(3);
        chk("R5", "fall in both mode", 32'(chan_pend[4]), 32'd1);
        // R9: tie on level 6 between channels 1 and 5, lowest wins
        tag = "R9"; wr(3'd4, 8'h00); wr(3'd6, 8'h22); wr(3'd1, 8'h06); wr(3'd5, 8'h06);
        irq_pin[5] = 1'b1; irq_pin[1] = 1'b1; idle(4);
        chk("R9", "tie to lowest", 32'({req_valid, req_chan, req_lvl}), 32'({1'b1, 3'd1, 3'd6}));
        wr(3'd1, 8'h00);
        chk("R9", "level 0 not forwarded", 32'({req_valid, req_chan}), 32'({1'b1, 3'd5}));
        // R7: clearing write on the event cycle
        tag = "R7"; wr(3'd6, 8'h00); wr(3'd0, 8'h03);
        irq_pin[0] = 1'b1; idle(4);
        irq_pin[0] = 1'b0; idle(2);
        wr(3'd0, 8'h03);
        chk("R7", "event beats clear", 32'(chan_pend[0]), 32'd1);
        // random mix (R3 R4 R5 R6 R9 R10)
        tag = "R9";
        for (int k = 0; k < 3000; k++) begin
            if ($urandom_range(0, 3) == 0) irq_pin = irq_pin ^ 6'($urandom);
            bus_addr  = 3'($urandom);
            bus_wdata = 8'($urandom);
            bus_wr    = ($urandom_range(0, 3) == 0);
            step();
        end
        bus_wr = 1'b0;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule